// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small, fully associative cache of page translations in which every entry carries the 16-bit identifier of the virtual processor that created it. The host context uses identifier 0. Each guest virtual processor has its own identifier in the range 1 to 65535. Because a lookup hits only on entries whose identifier equals the active one, host and guest translations can stay in the cache together. A switch between worlds only drives a new value onto the active-identifier input.

A lookup presents a virtual page number and returns, in the same cycle, a hit flag, the physical page, the size flag and the three access bits stored with the entry. A page walker refills the cache through a fill port. Each fill is recorded under the active identifier. The fill either allocates an entry in round-robin order or rewrites an entry that already holds the same page.

Three invalidate commands remove entries:
- one address within the active identifier;
- every entry of the active identifier;
- every entry in the cache.

An entry maps either a 4 KB page or a 2 MB page.

Top module: `vptag_tlb`

## Requirements
- R1: A synchronous active-low reset leaves every entry invalid, so no lookup hits after reset. A fill presented during reset is not stored.
- R2: A lookup hits only on a valid entry whose stored identifier equals `act_tag` and whose page matches `lk_vpn`. The result is combinational. A fill or invalidate takes effect at the next rising edge, not in the cycle it is presented. If several entries match, the lowest-numbered entry supplies the result.
- R3: An entry filled under one identifier never hits for a lookup under any other identifier, including host identifier 0.
- R4: Changing `act_tag` alone does not alter any stored entry. An entry filled earlier hits again once its identifier is made active again.
- R5: An entry filled with `fill_large`=1 maps a 2 MB page. It hits for any `lk_vpn` whose bits [35:9] equal those of the filled page. The returned physical page takes bits [PPN_W-1:9] from the entry and bits [8:0] from `lk_vpn`.
- R6: `inv_op`=2'b01 removes the entries of the active identifier whose page matches `inv_vpn`, using 2 MB matching for large entries. Entries of other identifiers are untouched.
- R7: `inv_op`=2'b10 removes every entry of the active identifier and keeps the entries of all other identifiers.
- R8: `inv_op`=2'b11 removes every entry regardless of identifier. `inv_op`=2'b00 removes nothing.
- R9: A fill that matches no existing entry writes the slot under a round-robin pointer over the 16 slots and then advances the pointer. After 17 distinct fills, the first of them has been evicted.
- R10: A fill whose identifier, size and page equal those of an existing entry rewrites that entry in place. It creates no duplicate and does not advance the round-robin pointer.
- R11: When an invalidate command selects the slot that a fill writes in the same cycle, the slot ends invalid. Selection is judged on the slot's contents before the edge.
- R12: A hit returns, unchanged, the three access bits (read = bit 0, write = bit 1, execute = bit 2) stored by the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| act_tag | input | 16 | Active virtual processor identifier; 0 is the host |
| lk_vpn | input | VPN_W (36) | Virtual page number to translate (address bits 47:12) |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_ppn | output | PPN_W (28) | Physical page of the hit |
| lk_perm | output | 3 | Access bits of the hit entry |
| lk_large | output | 1 | Hit entry maps a 2 MB page |
| fill_en | input | 1 | Store a translation under `act_tag` |
| fill_vpn | input | VPN_W (36) | Virtual page of the fill |
| fill_ppn | input | PPN_W (28) | Physical page of the fill |
| fill_large | input | 1 | Fill maps a 2 MB page |
| fill_perm | input | 3 | Access bits stored with the fill |
| inv_op | input | 2 | 00 none, 01 one address, 10 active identifier, 11 everything |
| inv_vpn | input | VPN_W (36) | Page to drop for the one-address command |

## Verification
The assertions assume that reset is held low for at least one rising edge before any other activity. They also assume that `inv_op` and `fill_en` are never unknown while reset is released, because the properties on entry counts and on the replacement pointer sample them at every edge. The stimulus drives every input on the falling edge from one sequential process, so each input holds a defined value across every sampling edge. Reset is asserted for several cycles at the start with a fill pending, and both directed and random phases keep identifiers and page numbers in narrow ranges. This makes tag collisions, overlaps between 2 MB and 4 KB pages, and same-cycle fill-and-invalidate pairs frequent.

// File: rtl/vtlb_pkg.sv
// Package: shared constants and the invalidate command encoding for the
// tagged translation cache. Assumes 4 KB base pages, so a 2 MB page spans
// LG_BITS low page-number bits.
package vtlb_pkg;
    localparam int TAG_W   = 16;
    localparam int LG_BITS = 9;
    localparam int PERM_W  = 3;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ADDR = 2'b01,
        INV_TAG  = 2'b10,
        INV_ALL  = 2'b11
    } inv_op_e;
endpackage

// File: rtl/vtlb_cmp.sv
// Module: compares one stored entry against one query. It reports the
// identifier match and, separately, the page match, which honours the
// entry's size. Assumes the entry fields are stable within the cycle.
module vtlb_cmp #(
    parameter int VPN_W   = 36,
    parameter int TAG_W   = 16,
    parameter int LG_BITS = 9
) (
    input  logic             e_valid,
    input  logic [TAG_W-1:0] e_tag,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic             e_large,
    input  logic [TAG_W-1:0] q_tag,
    input  logic [VPN_W-1:0] q_vpn,
    output logic             tag_hit,
    output logic             page_hit
);
    logic hi_eq;
    logic lo_eq;

    // identifier match counts only for a valid entry
    always_comb tag_hit = e_valid && (e_tag == q_tag);

    // a large entry ignores the low page bits
    always_comb begin
        hi_eq    = (e_vpn[VPN_W-1:LG_BITS] == q_vpn[VPN_W-1:LG_BITS]);
        lo_eq    = (e_vpn[LG_BITS-1:0] == q_vpn[LG_BITS-1:0]);
        page_hit = hi_eq && (e_large || lo_eq);
    end
endmodule

// File: rtl/vtlb_prio.sv
// Module: priority encoder. Returns the lowest set request index and
// whether any request is set. Assumes N is at least 2.
module vtlb_prio #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest index is written last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vtlb_rr.sv
// Module: round-robin victim pointer over N slots. It advances by one per
// allocation and wraps. Assumes adv is a defined value whenever rst_n is high.
module vtlb_rr #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    // pointer update with synchronous reset to slot 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
    end

    // R9: the pointer wraps from the last slot to the first
    a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == IDX_W'(N - 1)) |=> (ptr == '0));

    // R10: without an allocation the pointer holds
    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/vptag_tlb.sv
// Module: fully associative translation cache whose entries are tagged
// with a virtual processor identifier. Lookup is combinational. Fills are
// recorded under act_tag. Invalidates are judged on pre-edge contents and
// win over a fill to the same slot. Assumes a synchronous active-low reset
// before use and PPN_W > LG_BITS.
module vptag_tlb
    import vtlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 36,
    parameter int PPN_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  act_tag,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_large,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_large,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic [1:0]        inv_op,
    input  logic [VPN_W-1:0]  inv_vpn
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]      valid_q;
    logic [TAG_W-1:0]  tag_q  [N];
    logic [VPN_W-1:0]  vpn_q  [N];
    logic [PPN_W-1:0]  ppn_q  [N];
    logic [N-1:0]      large_q;
    logic [PERM_W-1:0] perm_q [N];

    logic [N-1:0] lk_tag_m, lk_pg_m, fl_tag_m, fl_pg_m, iv_tag_m, iv_pg_m;
    logic [N-1:0] lk_match, fill_dup, kill;

    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             dup_any;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] fill_tgt;
    logic             alloc;
    inv_op_e          op;

    always_comb op = inv_op_e'(inv_op);

    // per-slot comparators for lookup, fill duplicate search and invalidate
    for (genvar i = 0; i < N; i++) begin : g_slot
        vtlb_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W), .LG_BITS(LG_BITS)) u_lk (
            .e_valid(valid_q[i]), .e_tag(tag_q[i]), .e_vpn(vpn_q[i]),
            .e_large(large_q[i]), .q_tag(act_tag), .q_vpn(lk_vpn),
            .tag_hit(lk_tag_m[i]), .page_hit(lk_pg_m[i]));
        vtlb_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W), .LG_BITS(LG_BITS)) u_fl (
            .e_valid(valid_q[i]), .e_tag(tag_q[i]), .e_vpn(vpn_q[i]),
            .e_large(large_q[i]), .q_tag(act_tag), .q_vpn(fill_vpn),
            .tag_hit(fl_tag_m[i]), .page_hit(fl_pg_m[i]));
        vtlb_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W), .LG_BITS(LG_BITS)) u_iv (
            .e_valid(valid_q[i]), .e_tag(tag_q[i]), .e_vpn(vpn_q[i]),
            .e_large(large_q[i]), .q_tag(act_tag), .q_vpn(inv_vpn),
            .tag_hit(iv_tag_m[i]), .page_hit(iv_pg_m[i]));

        // combine the comparator outputs into per-slot decisions
        always_comb begin
            lk_match[i] = lk_tag_m[i] && lk_pg_m[i];
            fill_dup[i] = fl_tag_m[i] && fl_pg_m[i] && (large_q[i] == fill_large);
            unique case (op)
                INV_ALL:  kill[i] = 1'b1;
                INV_TAG:  kill[i] = iv_tag_m[i];
                INV_ADDR: kill[i] = iv_tag_m[i] && iv_pg_m[i];
                default:  kill[i] = 1'b0;
            endcase
        end
    end

    vtlb_prio #(.N(N)) u_hit_sel (.req(lk_match), .any(any_hit), .idx(hit_idx));
    vtlb_prio #(.N(N)) u_dup_sel (.req(fill_dup), .any(dup_any), .idx(dup_idx));

    // allocate a new slot only when the page is not already present
    always_comb begin
        alloc    = fill_en && !dup_any;
        fill_tgt = dup_any ? dup_idx : rr_ptr;
    end

    vtlb_rr #(.N(N)) u_rr (.clk(clk), .rst_n(rst_n), .adv(alloc), .ptr(rr_ptr));

    // lookup result; a large page passes the low page bits through
    always_comb begin
        lk_hit   = any_hit;
        lk_perm  = perm_q[hit_idx];
        lk_large = large_q[hit_idx];
        if (large_q[hit_idx])
            lk_ppn = {ppn_q[hit_idx][PPN_W-1:LG_BITS], lk_vpn[LG_BITS-1:0]};
        else
            lk_ppn = ppn_q[hit_idx];
    end

    // valid bits: reset clears, invalidate beats fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (kill[i])
                    valid_q[i] <= 1'b0;
                else if (fill_en && fill_tgt == IDX_W'(i))
                    valid_q[i] <= 1'b1;
            end
        end
    end

    // entry payload written on fill; needs no reset behind the valid bit
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst_n && fill_en && fill_tgt == IDX_W'(i)) begin
                tag_q[i]   <= act_tag;
                vpn_q[i]   <= fill_vpn;
                ppn_q[i]   <= fill_ppn;
                large_q[i] <= fill_large;
                perm_q[i]  <= fill_perm;
            end
        end
    end

    // R1: the cycle after reset holds no valid entry
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    // R8: a global invalidate leaves nothing valid
    a_r8_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inv_op) == INV_ALL) |-> (valid_q == '0));

    // R4: with no fill and no invalidate the valid set is unchanged
    a_r4_quiet_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_NONE && !fill_en) |=> $stable(valid_q));

    // R9: a fill adds at most one valid entry
    a_r9_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ($countones(valid_q) <= $countones($past(valid_q)) + 1));

    // R2: a reported hit comes from a valid entry of the active identifier
    a_r2_hit_own_tag: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q[hit_idx] && tag_q[hit_idx] == act_tag));
endmodule

// File: tb/vptag_tlb_tb_top.sv
// Bench: behavioural model of the cache (plain arrays and integers)
// compared with the design on every cycle, plus directed expectations.
module vptag_tlb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] act_tag;
    logic [35:0] lk_vpn;
    logic        lk_hit;
    logic [27:0] lk_ppn;
    logic [2:0]  lk_perm;
    logic        lk_large;
    logic        fill_en;
    logic [35:0] fill_vpn;
    logic [27:0] fill_ppn;
    logic        fill_large;
    logic [2:0]  fill_perm;
    logic [1:0]  inv_op;
    logic [35:0] inv_vpn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    bit     m_v   [N];
    int     m_tag [N];
    longint m_vpn [N];
    longint m_ppn [N];
    bit     m_lg  [N];
    int     m_perm[N];
    int     m_rr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vptag_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .act_tag(act_tag), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_large(lk_large),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_large(fill_large), .fill_perm(fill_perm),
        .inv_op(inv_op), .inv_vpn(inv_vpn));

    function automatic bit pg_match(input bit lg, input longint e, input longint q);
        if (lg) return (e >> 9) == (q >> 9);
        return e == q;
    endfunction

    // one cycle: drive, compare, advance model at the edge
    task automatic cyc(input string req, input int tag, input longint vpn,
                       input bit fe, input longint fv, input longint fp,
                       input bit fl, input int fperm, input int op, input longint iv,
                       input bit fixed, input bit eh, input longint ep, input int eperm);
        bit mh; longint mp; int mperm; bit mlg; bit ok;
        bit kill [N]; bit dup; int tgt;
        act_tag = 16'(tag); lk_vpn = 36'(vpn);
        fill_en = fe; fill_vpn = 36'(fv); fill_ppn = 28'(fp);
        fill_large = fl; fill_perm = 3'(fperm);
        inv_op = 2'(op); inv_vpn = 36'(iv);
        #1;
        if (rst_n) begin
            mh = 0; mp = 0; mperm = 0; mlg = 0;
            for (int i = 0; i < N; i++) begin
                if (!mh && m_v[i] && m_tag[i] == tag && pg_match(m_lg[i], m_vpn[i], vpn)) begin
                    mh = 1; mlg = m_lg[i]; mperm = m_perm[i];
                    mp = m_lg[i] ? (((m_ppn[i] >> 9) << 9) | (vpn & 64'h1FF)) : m_ppn[i];
                end
            end
            ok = (lk_hit == mh) && (!mh || (longint'(lk_ppn) == mp &&
                  int'(lk_perm) == mperm && lk_large == mlg));
            if (fixed)
                ok = ok && (mh == eh) && (!eh || (mp == ep && mperm == eperm));
            checks++;
            if (!ok) begin
                errors++;
                $display("FAIL %s: got hit=%0b ppn=%0h perm=%0d, expected hit=%0b ppn=%0h perm=%0d",
                         req, lk_hit, lk_ppn, lk_perm, fixed ? eh : mh,
                         fixed ? ep : mp, fixed ? eperm : mperm);
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0;
        end else begin
            dup = 0; tgt = m_rr;
            for (int i = 0; i < N; i++) begin
                kill[i] = (op == 3) ||
                          (op == 2 && m_v[i] && m_tag[i] == tag) ||
                          (op == 1 && m_v[i] && m_tag[i] == tag && pg_match(m_lg[i], m_vpn[i], iv));
                if (fe && !dup && m_v[i] && m_tag[i] == tag && m_lg[i] == fl &&
                    pg_match(m_lg[i], m_vpn[i], fv)) begin
                    dup = 1; tgt = i;
                end
            end
            for (int i = 0; i < N; i++) begin
                if (kill[i]) m_v[i] = 0;
                else if (fe && i == tgt) begin
                    m_v[i] = 1; m_tag[i] = tag; m_vpn[i] = fv; m_ppn[i] = fp;
                    m_lg[i] = fl; m_perm[i] = fperm;
                end
            end
            if (fe && !dup) m_rr = (m_rr + 1) % N;
        end
        @(negedge clk);
    endtask

    task automatic probe(input string req, input int tag, input longint vpn,
                         input bit eh, input longint ep, input int eperm);
        cyc(req, tag, vpn, 0, 0, 0, 0, 0, 0, 0, 1, eh, ep, eperm);
    endtask

    task automatic fill(input string req, input int tag, input longint fv,
                        input longint fp, input bit fl, input int fperm);
        cyc(req, tag, fv, 1, fv, fp, fl, fperm, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic inv(input string req, input int tag, input int op, input longint iv);
        cyc(req, tag, iv, 0, 0, 0, 0, 0, op, iv, 0, 0, 0, 0);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        // R1: a fill offered during reset must not be kept
        repeat (3) cyc("R1", 0, 5, 1, 5, 28'h123, 0, 7, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        probe("R1", 0, 5, 0, 0, 0);

        // R2: fill is invisible in its own cycle, visible after the edge
        cyc("R2", 0, 36'h100, 1, 36'h100, 28'hAAA, 0, 5, 0, 0, 1, 0, 0, 0);
        probe("R2", 0, 36'h100, 1, 28'hAAA, 5);
        probe("R12", 0, 36'h100, 1, 28'hAAA, 5);

        // R3: other identifiers miss
        probe("R3", 1, 36'h100, 0, 0, 0);
        probe("R3", 16'hFFFF, 36'h100, 0, 0, 0);

        // R4: world switches keep entries
        fill("R4", 1, 36'h100, 28'hBBB, 0, 3);
        probe("R4", 1, 36'h100, 1, 28'hBBB, 3);
        probe("R4", 0, 36'h100, 1, 28'hAAA, 5);
        probe("R3", 0, 36'h101, 0, 0, 0);

        // R5: 2 MB entry covers the whole large page
        fill("R5", 2, 36'h200, 28'h4400, 1, 6);
        probe("R5", 2, 36'h3FF, 1, 28'h45FF, 6);
        probe("R5", 2, 36'h200, 1, 28'h4400, 6);
        probe("R5", 2, 36'h400, 0, 0, 0);

        // R6: single-address invalidate is scoped to the active identifier
        inv("R6", 0, 1, 36'h100);
        probe("R6", 0, 36'h100, 0, 0, 0);
        probe("R6", 1, 36'h100, 1, 28'hBBB, 3);
        inv("R6", 2, 1, 36'h3AB);
        probe("R6", 2, 36'h201, 0, 0, 0);

        // R10: refill of a present page rewrites it in place
        fill("R10", 1, 36'h100, 28'hCCC, 0, 1);
        probe("R10", 1, 36'h100, 1, 28'hCCC, 1);
        probe("R12", 1, 36'h100, 1, 28'hCCC, 1);

        // R7: identifier-wide invalidate
        fill("R7", 5, 1, 28'h51, 0, 1);
        fill("R7", 5, 2, 28'h52, 0, 2);
        fill("R7", 6, 1, 28'h61, 0, 4);
        inv("R7", 5, 2, 0);
        probe("R7", 5, 1, 0, 0, 0);
        probe("R7", 5, 2, 0, 0, 0);
        probe("R7", 6, 1, 1, 28'h61, 4);

        // R9: 17 distinct fills evict the first one
        inv("R8", 0, 3, 0);
        for (int k = 0; k < 17; k++) fill("R9", 7, k, 28'h50 + k, 0, 7);
        probe("R9", 7, 0, 0, 0, 0);
        probe("R9", 7, 1, 1, 28'h51, 7);
        probe("R9", 7, 16, 1, 28'h60, 7);

        // R11: invalidate wins over a same-cycle fill to the same slot
        cyc("R11", 7, 1, 1, 1, 28'h999, 0, 2, 2, 0, 0, 0, 0, 0);
        probe("R11", 7, 1, 0, 0, 0);
        cyc("R11", 7, 3, 1, 3, 28'h777, 0, 2, 3, 0, 0, 0, 0, 0);
        probe("R11", 7, 3, 0, 0, 0);

        // R8: global invalidate clears every identifier
        fill("R8", 8, 9, 28'h89, 0, 1);
        fill("R8", 9, 9, 28'h99, 1, 1);
        probe("R8", 8, 9, 1, 28'h89, 1);
        inv("R8", 0, 0, 9);
        probe("R8", 9, 9, 1, 28'h9, 1);
        inv("R8", 0, 3, 0);
        probe("R8", 8, 9, 0, 0, 0);
        probe("R8", 9, 9, 0, 0, 0);

        // R2: random traffic compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int t; int o; int r;
            t = int'($urandom_range(0, 3));
            r = int'($urandom_range(0, 15));
            o = (r == 0) ? 3 : (r < 3) ? 2 : (r < 6) ? 1 : 0;
            cyc("R2", t, longint'($urandom_range(0, 2047)),
                $urandom_range(0, 1) == 1, longint'($urandom_range(0, 2047)),
                longint'($urandom & 32'h0FFFFFFF), $urandom_range(0, 3) == 0,
                int'($urandom_range(0, 7)), o, longint'($urandom_range(0, 2047)),
                0, 0, 0, 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule